// File: doc/BRIEF.md
# Debug System Control Register Block

This block is the always-present control endpoint of an on-chip debug subsystem. A host debug link reaches it through simple register read and write requests within the block's own small address space. The block answers with a fixed identification set (module class, vendor code, product code, revision) so that host tools can discover what they are talking to and adapt to its revision. It also answers with a configurable list of system information words, such as how many debug endpoints exist or how large the memory is.

One writable word controls two reset outputs. Its bit 0 holds the whole chip in reset and its bit 1 holds only the processor cores in reset. A typical host session sets both bits and then clears bit 0 so memories and peripherals come alive. While the cores stay held, the host loads memory and configures tracing. Clearing bit 1 then starts the cores. Each request gets one response one cycle after it is accepted. The response holds until the host takes it. A read of an address with nothing behind it returns zero and flags an error on that response.

Top module: `dbg_sysctl`

## Requirements
- R1: Reads of word 0, 1, 2 and 3 return the parameters TYPE_WORD, VENDOR_WORD, ID_WORD and VERSION_WORD respectively. Their error flag is low.
- R2: Reads of word 5+k, for k from 0 to NUM_INFO-1, return bits [k*DATA_W +: DATA_W] of the parameter INFO_WORDS. Their error flag is low.
- R3: A write to word 4 loads write-data bit 0 into `sys_rst_o` and bit 1 into `cpu_rst_o`, at the clock edge that accepts the write. A read of word 4 returns those two bits in positions 0 and 1, with zeros above them.
- R4: After `rst_n` is asserted, both reset outputs are 0, `rsp_valid` is 0 and `req_ready` is 1.
- R5: Writes to words 0 to 3, to information words, or to unmapped addresses change neither reset output nor any read value.
- R6: A read of an address at or above 5+NUM_INFO returns data 0 with `rsp_err` high. The error flag is cleared once that response has been taken. No other response raises it.
- R7: An accepted request (`req_valid` and `req_ready` high at a clock edge) produces `rsp_valid` from that edge on. The response data and error flag stay unchanged, and `req_ready` stays low, until `rsp_ready` is seen high. Write responses carry data 0.
- R8: The two reset bits are independent. The host can release `sys_rst_o` while `cpu_rst_o` stays high, and later release `cpu_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | DATA_W | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Read of an unmapped address |
| sys_rst_o | output | 1 | Whole-system reset request, active high |
| cpu_rst_o | output | 1 | Processor-only reset request, active high |

## Verification
The bench builds the block with ADDR_W=4, DATA_W=16 and NUM_INFO=3. Mapped words are then 0 to 7 and words 8 to 15 are unmapped. This small map lets the bench read and write every address, including the whole unmapped span. It also drives all four reset-bit combinations and checks them against values derived from the chosen parameters. Back-pressure on the response side is exercised to show that data stays stable and no request is taken while a response waits.

// File: rtl/dbg_sysctl_pkg.sv
package dbg_sysctl_pkg;

   typedef enum logic [1:0] {
      REG_ID   = 2'd0,
      REG_RST  = 2'd1,
      REG_INFO = 2'd2,
      REG_NONE = 2'd3
   } reg_kind_e;

   localparam int unsigned ID_WORDS  = 4;
   localparam int unsigned RST_WORD  = 4;
   localparam int unsigned INFO_BASE = 5;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dbg_sysctl_decode.sv
module dbg_sysctl_decode
   import dbg_sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_INFO = 2,
   parameter int unsigned IDX_W    = 1
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [IDX_W-1:0]  info_idx
);

   localparam logic [31:0] INFO_END = 32'(INFO_BASE + NUM_INFO);

   logic [31:0] a32;
   logic [31:0] rel;

   assign a32 = 32'(addr);
   assign rel = a32 - 32'(INFO_BASE);

   always_comb begin
      info_idx = '0;
      if (a32 < 32'(ID_WORDS)) begin
         kind = REG_ID;
      end else if (a32 == 32'(RST_WORD)) begin
         kind = REG_RST;
      end else if (a32 < INFO_END) begin
         kind     = REG_INFO;
         info_idx = rel[IDX_W-1:0];
      end else begin
         kind = REG_NONE;
      end
   end

   logic unused_rel_hi;
   assign unused_rel_hi = ^rel;

endmodule

// File: rtl/dbg_sysctl_rdmux.sv
module dbg_sysctl_rdmux
   import dbg_sysctl_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_INFO = 2,
   parameter int unsigned IDX_W    = 1,
   parameter logic [DATA_W-1:0] TYPE_WORD    = '0,
   parameter logic [DATA_W-1:0] VENDOR_WORD  = '0,
   parameter logic [DATA_W-1:0] ID_WORD      = '0,
   parameter logic [DATA_W-1:0] VERSION_WORD = '0,
   parameter logic [NUM_INFO*DATA_W-1:0] INFO_WORDS = '0
) (
   input  reg_kind_e         kind,
   input  logic [1:0]        id_sel,
   input  logic [IDX_W-1:0]  info_idx,
   input  logic [1:0]        rst_state,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] info_arr [NUM_INFO];

   for (genvar g = 0; g < NUM_INFO; g++) begin : g_info
      assign info_arr[g] = INFO_WORDS[g*DATA_W +: DATA_W];
   end

   logic [DATA_W-1:0] id_word;
   always_comb begin
      unique case (id_sel)
         2'd0:    id_word = TYPE_WORD;
         2'd1:    id_word = VENDOR_WORD;
         2'd2:    id_word = ID_WORD;
         default: id_word = VERSION_WORD;
      endcase
   end

   logic [DATA_W-1:0] info_word;
   if (NUM_INFO == 1) begin : g_one_info
      assign info_word = info_arr[0];
      logic unused_idx;
      assign unused_idx = ^info_idx;
   end else begin : g_many_info
      always_comb begin
         info_word = '0;
         if (32'(info_idx) < 32'(NUM_INFO)) info_word = info_arr[info_idx];
      end
   end

   always_comb begin
      unique case (kind)
         REG_ID:   rdata = id_word;
         REG_RST:  rdata = {{(DATA_W-2){1'b0}}, rst_state};
         REG_INFO: rdata = info_word;
         default:  rdata = '0;
      endcase
   end

endmodule

// File: rtl/dbg_sysctl_rstreg.sv
module dbg_sysctl_rstreg (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_bits,
   output logic [1:0] state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     state <= 2'b00;
      else if (wr_en) state <= wr_bits;
   end

   assert_rst_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> state == $past(wr_bits));

   assert_rst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(state));

endmodule

// File: rtl/dbg_sysctl_rsp.sv
module dbg_sysctl_rsp #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] rdata_d,
   input  logic              err_d,
   input  logic              rsp_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_rdata <= rdata_d;
         rsp_err   <= err_d;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
      end
   end

   assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);

   assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

   assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> rsp_rdata == '0);

endmodule

// File: rtl/dbg_sysctl.sv
module dbg_sysctl
   import dbg_sysctl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_INFO = 2,
   parameter logic [DATA_W-1:0] TYPE_WORD    = DATA_W'(1),
   parameter logic [DATA_W-1:0] VENDOR_WORD  = DATA_W'(1),
   parameter logic [DATA_W-1:0] ID_WORD      = DATA_W'(1),
   parameter logic [DATA_W-1:0] VERSION_WORD = DATA_W'(0),
   parameter logic [NUM_INFO*DATA_W-1:0] INFO_WORDS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              sys_rst_o,
   output logic              cpu_rst_o
);

   localparam int unsigned IDX_W    = idx_width(NUM_INFO);
   localparam int unsigned MAP_SIZE = INFO_BASE + NUM_INFO;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("dbg_sysctl: DATA_W must be at least 2");
   end
   if (NUM_INFO < 1) begin : g_bad_num_info
      $error("dbg_sysctl: NUM_INFO must be at least 1");
   end
   if (ADDR_W < 3 || ADDR_W > 30 || MAP_SIZE > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("dbg_sysctl: ADDR_W cannot hold the register map");
   end

   reg_kind_e         kind;
   logic [IDX_W-1:0]  info_idx;
   logic [1:0]        rst_state;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rdata_d;
   logic              accept;
   logic              rst_wr;
   logic              err_d;

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;
   assign rst_wr    = accept && req_write && (kind == REG_RST);
   assign err_d     = !req_write && (kind == REG_NONE);
   assign rdata_d   = req_write ? '0 : rd_word;

   dbg_sysctl_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_INFO(NUM_INFO),
      .IDX_W   (IDX_W)
   ) i_decode (
      .addr    (req_addr),
      .kind    (kind),
      .info_idx(info_idx)
   );

   dbg_sysctl_rdmux #(
      .DATA_W      (DATA_W),
      .NUM_INFO    (NUM_INFO),
      .IDX_W       (IDX_W),
      .TYPE_WORD   (TYPE_WORD),
      .VENDOR_WORD (VENDOR_WORD),
      .ID_WORD     (ID_WORD),
      .VERSION_WORD(VERSION_WORD),
      .INFO_WORDS  (INFO_WORDS)
   ) i_rdmux (
      .kind     (kind),
      .id_sel   (req_addr[1:0]),
      .info_idx (info_idx),
      .rst_state(rst_state),
      .rdata    (rd_word)
   );

   dbg_sysctl_rstreg i_rstreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (rst_wr),
      .wr_bits(req_wdata[1:0]),
      .state  (rst_state)
   );

   dbg_sysctl_rsp #(
      .DATA_W(DATA_W)
   ) i_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .rdata_d  (rdata_d),
      .err_d    (err_d),
      .rsp_ready(rsp_ready),
      .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata),
      .rsp_err  (rsp_err)
   );

   assign sys_rst_o = rst_state[0];
   assign cpu_rst_o = rst_state[1];

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^req_wdata[DATA_W-1:2];

   assert_err_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_write) |=> !rsp_err);

   assert_err_in_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

endmodule

// File: tb/test_dbg_sysctl.sv
`timescale 1ns/1ps
module test_dbg_sysctl;

   localparam int AW = 4;
   localparam int DW = 16;
   localparam int NI = 3;
   localparam logic [DW-1:0] T_TYPE = 16'h0A01;
   localparam logic [DW-1:0] T_VEND = 16'h00C3;
   localparam logic [DW-1:0] T_ID   = 16'h0042;
   localparam logic [DW-1:0] T_VER  = 16'h0107;
   localparam logic [NI*DW-1:0] T_INFO = {16'h0008, 16'h4000, 16'h0005};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, rsp_err, sys_rst_o, cpu_rst_o;
   logic [DW-1:0] rsp_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dbg_sysctl #(
      .ADDR_W(AW), .DATA_W(DW), .NUM_INFO(NI),
      .TYPE_WORD(T_TYPE), .VENDOR_WORD(T_VEND), .ID_WORD(T_ID),
      .VERSION_WORD(T_VER), .INFO_WORDS(T_INFO)
   ) i_dbg_sysctl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
      .rsp_err(rsp_err), .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input int a, input logic [1:0] rs);
      if (a == 0) return T_TYPE;
      if (a == 1) return T_VEND;
      if (a == 2) return T_ID;
      if (a == 3) return T_VER;
      if (a == 4) return {14'd0, rs};
      if (a < 5 + NI) return T_INFO[(a-5)*DW +: DW];
      return '0;
   endfunction

   task automatic xact(input bit w, input int a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output logic er);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
      @(posedge clk); #1;
      chk(rsp_valid === 1'b1, "R7", "rsp_valid after accept", 32'(rsp_valid), 1);
      rd = rsp_rdata; er = rsp_err;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic chk_rst(input logic [1:0] exp, input string req);
      chk({cpu_rst_o, sys_rst_o} === exp, req, "reset outputs {cpu,sys}",
          32'({cpu_rst_o, sys_rst_o}), 32'(exp));
   endtask

   initial begin
      logic [DW-1:0] rd;
      logic er;
      logic [1:0] rs;

      #1;
      chk(rsp_valid === 1'b0, "R4", "rsp_valid in reset", 32'(rsp_valid), 0);
      chk(req_ready === 1'b1, "R4", "req_ready in reset", 32'(req_ready), 1);
      chk_rst(2'b00, "R4");
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 R2 R6: read every address
      for (int a = 0; a < (1 << AW); a++) begin
         xact(1'b0, a, '0, rd, er);
         chk(rd === exp_read(a, 2'b00), (a < 4) ? "R1" : (a < 5 + NI) ? "R2" : "R6",
             $sformatf("read word %0d", a), 32'(rd), 32'(exp_read(a, 2'b00)));
         chk(er === (a >= 5 + NI), "R6", $sformatf("err flag word %0d", a), 32'(er),
             32'(a >= 5 + NI));
         @(posedge clk); #1;
         chk(rsp_err === 1'b0 && rsp_valid === 1'b0, "R6", "err cleared after taken",
             32'({rsp_valid, rsp_err}), 0);
      end

      // R3: every reset-bit combination, upper write bits ignored
      for (int v = 0; v < 4; v++) begin
         xact(1'b1, 4, DW'(16'hFFFC | v), rd, er);
         chk_rst(2'(v), "R3");
         chk(rd === '0, "R7", "write response data", 32'(rd), 0);
         xact(1'b0, 4, '0, rd, er);
         chk(rd === DW'(v), "R3", "reset readback", 32'(rd), 32'(v));
      end

      // R5: writes to every other address ignored
      xact(1'b1, 4, 16'h0001, rd, er);
      for (int a = 0; a < (1 << AW); a++) begin
         if (a == 4) continue;
         xact(1'b1, a, 16'hFFFF, rd, er);
         chk_rst(2'b01, "R5");
         chk(er === 1'b0, "R5", "no err on write", 32'(er), 0);
      end
      for (int a = 0; a < (1 << AW); a++) begin
         xact(1'b0, a, '0, rd, er);
         chk(rd === exp_read(a, 2'b01), "R5", $sformatf("reread word %0d", a),
             32'(rd), 32'(exp_read(a, 2'b01)));
      end

      // R8: host bring-up sequence
      xact(1'b1, 4, 16'h0003, rd, er);
      chk_rst(2'b11, "R8");
      xact(1'b1, 4, 16'h0002, rd, er);
      chk_rst(2'b10, "R8");
      repeat (5) @(posedge clk);
      #1 chk_rst(2'b10, "R8");
      xact(1'b1, 4, 16'h0000, rd, er);
      chk_rst(2'b00, "R8");

      // R7: back-pressure
      @(negedge clk);
      rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd2;
      @(posedge clk); #1;
      chk(rsp_valid === 1'b1 && rsp_rdata === T_ID, "R7", "first rsp data",
          32'(rsp_rdata), 32'(T_ID));
      @(negedge clk) req_addr = 4'd3;
      #1 chk(req_ready === 1'b0, "R7", "req_ready low while held", 32'(req_ready), 0);
      @(posedge clk); #1;
      chk(rsp_valid === 1'b1 && rsp_rdata === T_ID, "R7", "held rsp data",
          32'(rsp_rdata), 32'(T_ID));
      @(negedge clk) rsp_ready = 1'b1;
      @(posedge clk); #1;
      chk(rsp_valid === 1'b1 && rsp_rdata === T_VER, "R7", "second rsp data",
          32'(rsp_rdata), 32'(T_VER));
      @(negedge clk) req_valid = 1'b0;
      @(posedge clk); #1;
      chk(rsp_valid === 1'b0, "R7", "rsp drops after taken", 32'(rsp_valid), 0);

      // R4: reset clears reset outputs
      xact(1'b1, 4, 16'h0003, rd, er);
      @(negedge clk) rst_n = 1'b0;
      #1 chk_rst(2'b00, "R4");
      chk(rsp_valid === 1'b0, "R4", "rsp_valid after reset", 32'(rsp_valid), 0);
      @(negedge clk) rst_n = 1'b1;
      xact(1'b0, 4, '0, rd, er);
      rs = rd[1:0];
      chk(rs === 2'b00, "R4", "reset reg readback after reset", 32'(rs), 0);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule